// File: doc/BRIEF.md
# USB endpoint bank handshake controller

This block holds the status flags that let firmware and a USB device engine share an endpoint's data banks without trampling each other. For each endpoint it keeps a setup-received flag, an out-received flag, an in-ready flag, a FIFO-control flag, one busy bit per bank and the bank index that firmware is working on. The engine reports stored SETUP packets, stored OUT packets and transmitted IN banks. Firmware answers with one-cycle clear strobes. The block combines the flags with their enables into a single endpoint interrupt.

How a clear behaves depends on the endpoint type. On a control endpoint there is a single bank. Clearing an acknowledge flag releases that bank, or queues it for sending. On isochronous, bulk and interrupt endpoints, one to three banks form a ring. Clearing an acknowledge flag only acknowledges it. Clearing the FIFO-control flag hands the bank over and moves firmware to the next bank. The engine follows the same ring with a pointer of its own. Packet parsing, CRC and the data storage sit outside this block.

Top module: `ep_bank_ctrl`

## Requirements
- R1: While reset is low, and at the first sampling after reset is released before any clock edge, every flag, every busy bit, the bank index and the interrupt are 0.
- R2: On a control endpoint (`ep_type_i` = 2'b00), a SETUP event sets the setup flag and marks bank 0 busy on the next edge. A setup clear drops both on the next edge.
- R3: On a control endpoint, an OUT event sets the out flag and marks bank 0 busy. An out clear drops both.
- R4: On a control endpoint, the in flag is 1 after any edge that leaves bank 0 free. An in clear while the in flag is 1 marks the bank busy, which drops the flag. An IN-sent event frees the bank and raises the flag again.
- R5: On a non-control OUT endpoint (`ep_dir_in_i` = 0), the out flag and the FIFO-control flag rise together on the edge where firmware's current bank becomes full. An out clear drops only the out flag and leaves the busy bits unchanged.
- R6: On a non-control IN endpoint (`ep_dir_in_i` = 1), the in flag and the FIFO-control flag rise together on the edge where the current bank is free. An in clear drops only the in flag and leaves the busy bits unchanged.
- R7: On a non-control endpoint, a FIFO clear while the acknowledge flag for the direction is 0 does three things. It frees the current bank (OUT) or marks it busy (IN). It advances `bank_sel_o` modulo the bank count, where `bank_cnt_i` values 1 to 3 select that many banks and 0 selects one. Both flags then reload from the new bank's state.
- R8: A FIFO clear while the direction's acknowledge flag is 1 is ignored: the FIFO-control flag, the busy bits and the bank index are unchanged.
- R9: The setup flag stays 0 on non-control endpoints. The out flag stays 0 on IN endpoints and the in flag stays 0 on OUT endpoints. On a control endpoint the FIFO-control flag and the bank index stay 0, only bank 0 is used, and a FIFO clear has no effect.
- R10: `irq_o` is 1 exactly when at least one of setup, out or in flags is 1 with its own enable input 1. It follows the enables without a clock edge.
- R11: When an event and a clear of the same flag arrive in one cycle, the flag is 1 after the edge.
- R12: On a non-control endpoint the engine fills (OUT) or drains (IN) banks in ring order starting at bank 0. An OUT event aimed at a busy bank is dropped, and an IN-sent event aimed at a free bank is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_type_i | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ep_dir_in_i | input | 1 | Non-control direction: 1 IN, 0 OUT |
| bank_cnt_i | input | CNT_W (2) | Number of banks, 0 treated as 1, values above MAX_BANKS clamped |
| setup_evt_i | input | 1 | Engine stored a SETUP packet |
| out_evt_i | input | 1 | Engine stored an OUT packet |
| in_sent_i | input | 1 | Engine finished sending an IN bank |
| clr_setup_i | input | 1 | Firmware clears the setup flag |
| clr_out_i | input | 1 | Firmware clears the out flag |
| clr_in_i | input | 1 | Firmware clears the in flag |
| clr_fifo_i | input | 1 | Firmware clears the FIFO-control flag |
| en_setup_i | input | 1 | Interrupt enable for the setup flag |
| en_out_i | input | 1 | Interrupt enable for the out flag |
| en_in_i | input | 1 | Interrupt enable for the in flag |
| setup_flag_o | output | 1 | Setup-received flag |
| out_flag_o | output | 1 | Out-received flag |
| in_flag_o | output | 1 | In-ready flag |
| fifo_ctl_o | output | 1 | FIFO-control flag |
| bank_busy_o | output | MAX_BANKS (3) | Per-bank busy bits: holds OUT data, or holds queued IN data |
| bank_sel_o | output | BANK_W (2) | Bank firmware is working on |
| irq_o | output | 1 | Masked endpoint interrupt |

## Verification
The hardest states to reach are the ring wrap with every bank busy and the reload of the flags from a bank other than the one just released. Reaching them takes a run of clear pairs in the right order. For IN, the bench issues in clear then FIFO clear three times on a three-bank ring, which brings the index back to 0 with all banks queued and both flags low. IN-sent events then drain the ring, and the first of them must raise the flags again. For OUT, two engine events fill a two-bank ring and a third must be dropped. A premature FIFO clear is tried before the acknowledge, then the two banks are released in order so that the flags reload from bank 1 and the index wraps to 0.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;
endpackage

// File: rtl/ep_bank_ring.sv
module ep_bank_ring #(
  parameter int MAX_BANKS = 3,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 is_ctrl_i,
  input  logic                 dir_in_i,
  input  logic [CNT_W-1:0]     bank_cnt_i,
  input  logic                 out_evt_i,
  input  logic                 in_sent_i,
  input  logic                 fifo_rel_i,
  input  logic                 ctl_fill_i,
  input  logic                 ctl_free_i,
  output logic [MAX_BANKS-1:0] busy_o,
  output logic [MAX_BANKS-1:0] busy_nxt_o,
  output logic [BANK_W-1:0]    fw_ptr_o,
  output logic [BANK_W-1:0]    fw_ptr_nxt_o
);

  logic [MAX_BANKS-1:0] busy_q, busy_d;
  logic [BANK_W-1:0]    fw_q, fw_d, eng_q, eng_d;
  logic [CNT_W-1:0]     cnt_eff;
  logic                 eng_acc;

  function automatic logic [BANK_W-1:0] ring_step(input logic [BANK_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
    if (32'(p) + 32'd1 >= 32'(n)) return '0;
    return p + BANK_W'(1);
  endfunction

  always_comb begin
    if (is_ctrl_i || bank_cnt_i == '0)             cnt_eff = CNT_W'(1);
    else if (32'(bank_cnt_i) > MAX_BANKS)          cnt_eff = CNT_W'(MAX_BANKS);
    else                                           cnt_eff = bank_cnt_i;
  end

  // engine side: OUT fills a free bank, IN drains a queued one
  always_comb begin
    eng_acc = 1'b0;
    if (!is_ctrl_i) begin
      if (dir_in_i) eng_acc = in_sent_i &  busy_q[eng_q];
      else          eng_acc = out_evt_i & ~busy_q[eng_q];
    end
  end

  always_comb begin
    busy_d = busy_q;
    for (int b = 0; b < MAX_BANKS; b++) begin
      if (is_ctrl_i) begin
        if (b == 0) begin
          if (ctl_fill_i)      busy_d[b] = 1'b1;
          else if (ctl_free_i) busy_d[b] = 1'b0;
        end
      end else begin
        if (fifo_rel_i && fw_q == BANK_W'(b)) busy_d[b] = dir_in_i;
        if (eng_acc && eng_q == BANK_W'(b))   busy_d[b] = ~dir_in_i;
      end
    end
  end

  assign fw_d  = fifo_rel_i ? ring_step(fw_q, cnt_eff)  : fw_q;
  assign eng_d = eng_acc    ? ring_step(eng_q, cnt_eff) : eng_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      fw_q   <= '0;
      eng_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fw_q   <= fw_d;
      eng_q  <= eng_d;
    end
  end

  assign busy_o       = busy_q;
  assign busy_nxt_o   = busy_d;
  assign fw_ptr_o     = fw_q;
  assign fw_ptr_nxt_o = fw_d;

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fw_q) < 32'(cnt_eff)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rel_i |=> $stable(fw_q)); // R8
  AST_CTRL_BANK0_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ctrl_i |-> (busy_q >> 1) == '0); // R9

endmodule

// File: rtl/ep_flag_unit.sv
module ep_flag_unit #(
  parameter int MAX_BANKS = 3,
  parameter int BANK_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 is_ctrl_i,
  input  logic                 dir_in_i,
  input  logic                 setup_evt_i,
  input  logic                 out_evt_i,
  input  logic                 in_sent_i,
  input  logic                 clr_setup_i,
  input  logic                 clr_out_i,
  input  logic                 clr_in_i,
  input  logic                 clr_fifo_i,
  input  logic [MAX_BANKS-1:0] busy_nxt_i,
  input  logic [BANK_W-1:0]    fw_ptr_nxt_i,
  output logic                 setup_o,
  output logic                 out_o,
  output logic                 in_o,
  output logic                 fifo_o,
  output logic                 fifo_rel_o,
  output logic                 ctl_fill_o,
  output logic                 ctl_free_o
);

  logic setup_q, out_q, in_q, fifo_q;
  logic setup_d, out_d, in_d, fifo_d;
  logic ack_q, rdy_nxt, load;

  assign ack_q = dir_in_i ? in_q : out_q;

  // acknowledge must be cleared before the bank can be handed over
  assign fifo_rel_o = ~is_ctrl_i & fifo_q & clr_fifo_i & ~ack_q;
  assign ctl_fill_o = is_ctrl_i & (setup_evt_i | out_evt_i | (clr_in_i & in_q));
  assign ctl_free_o = is_ctrl_i & (clr_setup_i | clr_out_i | in_sent_i);

  // bank at the next pointer is ready for firmware after this edge
  assign rdy_nxt = dir_in_i ? ~busy_nxt_i[fw_ptr_nxt_i] : busy_nxt_i[fw_ptr_nxt_i];
  assign load    = rdy_nxt & (fifo_rel_o | ~fifo_q);

  always_comb begin
    if (is_ctrl_i) begin
      setup_d = setup_evt_i | (setup_q & ~clr_setup_i);
      out_d   = out_evt_i   | (out_q   & ~clr_out_i);
      in_d    = ~busy_nxt_i[0];
      fifo_d  = 1'b0;
    end else begin
      setup_d = 1'b0;
      out_d   = ~dir_in_i & (load | (out_q & ~clr_out_i));
      in_d    =  dir_in_i & (load | (in_q  & ~clr_in_i));
      fifo_d  = fifo_rel_o ? rdy_nxt : (fifo_q | rdy_nxt);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= 1'b0;
      out_q   <= 1'b0;
      in_q    <= 1'b0;
      fifo_q  <= 1'b0;
    end else begin
      setup_q <= setup_d;
      out_q   <= out_d;
      in_q    <= in_d;
      fifo_q  <= fifo_d;
    end
  end

  assign setup_o = setup_q;
  assign out_o   = out_q;
  assign in_o    = in_q;
  assign fifo_o  = fifo_q;

  AST_SETUP_CTRL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ctrl_i |-> !setup_q); // R9
  AST_SETUP_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ctrl_i && setup_evt_i) |=> setup_q); // R11
  AST_FIFO_CLR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_ctrl_i && fifo_q && clr_fifo_i && ack_q) |=> fifo_q); // R8
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ctrl_i |-> !(out_q && in_q)); // R9

endmodule

// File: rtl/ep_irq_mask.sv
module ep_irq_mask #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = flag_i[i] & en_i[i];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter  int MAX_BANKS = 3,
  localparam int BANK_W    = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1,
  localparam int CNT_W     = $clog2(MAX_BANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           ep_type_i,
  input  logic                 ep_dir_in_i,
  input  logic [CNT_W-1:0]     bank_cnt_i,
  input  logic                 setup_evt_i,
  input  logic                 out_evt_i,
  input  logic                 in_sent_i,
  input  logic                 clr_setup_i,
  input  logic                 clr_out_i,
  input  logic                 clr_in_i,
  input  logic                 clr_fifo_i,
  input  logic                 en_setup_i,
  input  logic                 en_out_i,
  input  logic                 en_in_i,
  output logic                 setup_flag_o,
  output logic                 out_flag_o,
  output logic                 in_flag_o,
  output logic                 fifo_ctl_o,
  output logic [MAX_BANKS-1:0] bank_busy_o,
  output logic [BANK_W-1:0]    bank_sel_o,
  output logic                 irq_o
);

  logic                 is_ctrl;
  logic                 fifo_rel, ctl_fill, ctl_free;
  logic [MAX_BANKS-1:0] busy_nxt;
  logic [BANK_W-1:0]    fw_ptr_nxt;

  assign is_ctrl = (ep_type_i == EP_CTRL);

  ep_bank_ring #(
    .MAX_BANKS (MAX_BANKS),
    .BANK_W    (BANK_W),
    .CNT_W     (CNT_W)
  ) i_ring (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .is_ctrl_i    (is_ctrl),
    .dir_in_i     (ep_dir_in_i),
    .bank_cnt_i   (bank_cnt_i),
    .out_evt_i    (out_evt_i),
    .in_sent_i    (in_sent_i),
    .fifo_rel_i   (fifo_rel),
    .ctl_fill_i   (ctl_fill),
    .ctl_free_i   (ctl_free),
    .busy_o       (bank_busy_o),
    .busy_nxt_o   (busy_nxt),
    .fw_ptr_o     (bank_sel_o),
    .fw_ptr_nxt_o (fw_ptr_nxt)
  );

  ep_flag_unit #(
    .MAX_BANKS (MAX_BANKS),
    .BANK_W    (BANK_W)
  ) i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .is_ctrl_i    (is_ctrl),
    .dir_in_i     (ep_dir_in_i),
    .setup_evt_i  (setup_evt_i),
    .out_evt_i    (out_evt_i),
    .in_sent_i    (in_sent_i),
    .clr_setup_i  (clr_setup_i),
    .clr_out_i    (clr_out_i),
    .clr_in_i     (clr_in_i),
    .clr_fifo_i   (clr_fifo_i),
    .busy_nxt_i   (busy_nxt),
    .fw_ptr_nxt_i (fw_ptr_nxt),
    .setup_o      (setup_flag_o),
    .out_o        (out_flag_o),
    .in_o         (in_flag_o),
    .fifo_o       (fifo_ctl_o),
    .fifo_rel_o   (fifo_rel),
    .ctl_fill_o   (ctl_fill),
    .ctl_free_o   (ctl_free)
  );

  ep_irq_mask #(.N_SRC(3)) i_irq (
    .flag_i ({in_flag_o, out_flag_o, setup_flag_o}),
    .en_i   ({en_in_i, en_out_i, en_setup_i}),
    .irq_o  (irq_o)
  );

  AST_CTRL_NO_FIFO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ctrl |-> (!fifo_ctl_o && bank_sel_o == '0)); // R9
  AST_OUT_ACK_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_ctrl && !ep_dir_in_i && clr_out_i && !clr_fifo_i && !out_evt_i)
      |=> $stable(bank_busy_o)); // R5

endmodule

// File: tb/test_ep_bank_ctrl.sv
module test_ep_bank_ctrl;
  localparam int MAX_BANKS = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] ep_type_i = 2'b00;
  logic       ep_dir_in_i = 1'b0;
  logic [1:0] bank_cnt_i = 2'd1;
  logic setup_evt_i = 0, out_evt_i = 0, in_sent_i = 0;
  logic clr_setup_i = 0, clr_out_i = 0, clr_in_i = 0, clr_fifo_i = 0;
  logic en_setup_i = 0, en_out_i = 0, en_in_i = 0;
  logic setup_flag_o, out_flag_o, in_flag_o, fifo_ctl_o, irq_o;
  logic [MAX_BANKS-1:0] bank_busy_o;
  logic [1:0] bank_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  ep_bank_ctrl #(.MAX_BANKS(MAX_BANKS)) i_ep_bank_ctrl (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // state = {setup,out,in,fifo,busy[2:0],sel[1:0]}
  task automatic chk_all(input string req, input int exp);
    chk(req, int'({setup_flag_o, out_flag_o, in_flag_o, fifo_ctl_o,
                   bank_busy_o, bank_sel_o}), exp);
  endtask

  function automatic int st(input bit s, input bit o, input bit i, input bit f,
                            input int busy, input int sel);
    return int'({s, o, i, f, 3'(busy), 2'(sel)});
  endfunction

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
    {setup_evt_i, out_evt_i, in_sent_i} = '0;
    {clr_setup_i, clr_out_i, clr_in_i, clr_fifo_i} = '0;
  endtask

  task automatic do_reset(input logic [1:0] ty, input logic dir, input logic [1:0] cnt);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ep_type_i = ty; ep_dir_in_i = dir; bank_cnt_i = cnt;
    @(negedge clk_i);
    chk_all("R1 during reset", 0);
    chk("R1 irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    #1;
    chk_all("R1 after release", 0);
    @(negedge clk_i);
  endtask

  task automatic t_control;
    en_setup_i = 1; en_out_i = 0; en_in_i = 0;
    do_reset(2'b00, 1'b0, 2'd3);
    tick;
    chk_all("R4 in ready when free", st(0,0,1,0,0,0));
    setup_evt_i = 1; tick;
    chk_all("R2 setup stored", st(1,0,0,0,1,0));
    chk("R10 irq setup", int'(irq_o), 1);
    clr_setup_i = 1; tick;
    chk_all("R2 setup cleared", st(0,0,1,0,0,0));
    out_evt_i = 1; tick;
    chk_all("R3 out stored", st(0,1,0,0,1,0));
    chk("R10 masked out", int'(irq_o), 0);
    clr_out_i = 1; tick;
    chk_all("R3 out cleared", st(0,0,1,0,0,0));
    clr_in_i = 1; tick;
    chk_all("R4 in queued", st(0,0,0,0,1,0));
    in_sent_i = 1; tick;
    chk_all("R4 in sent", st(0,0,1,0,0,0));
    en_in_i = 1; #1;
    chk("R10 irq follows enable", int'(irq_o), 1);
    en_in_i = 0;
    setup_evt_i = 1; clr_setup_i = 1; tick;
    chk_all("R11 setup set wins", st(1,0,0,0,1,0));
    clr_setup_i = 1; tick;
    clr_fifo_i = 1; tick;
    chk_all("R9 ctrl fifo clear no effect", st(0,0,1,0,0,0));
  endtask

  task automatic t_bulk_out;
    en_setup_i = 0; en_out_i = 0; en_in_i = 0;
    do_reset(2'b10, 1'b0, 2'd2);
    tick;
    chk_all("R5 idle out", st(0,0,0,0,0,0));
    out_evt_i = 1; tick;
    chk_all("R5 bank0 full", st(0,1,0,1,1,0));
    out_evt_i = 1; tick;
    chk_all("R12 bank1 filled", st(0,1,0,1,3,0));
    out_evt_i = 1; tick;
    chk_all("R12 drop when full", st(0,1,0,1,3,0));
    clr_fifo_i = 1; tick;
    chk_all("R8 fifo clear before ack", st(0,1,0,1,3,0));
    clr_out_i = 1; tick;
    chk_all("R5 ack keeps bank", st(0,0,0,1,3,0));
    clr_fifo_i = 1; tick;
    chk_all("R7 release and reload", st(0,1,0,1,2,1));
    clr_out_i = 1; tick;
    clr_fifo_i = 1; tick;
    chk_all("R7 wrap to empty bank0", st(0,0,0,0,0,0));
    out_evt_i = 1; clr_out_i = 1; tick;
    chk_all("R11 out set wins", st(0,1,0,1,1,0));
    chk("R10 out masked", int'(irq_o), 0);
    en_out_i = 1; #1;
    chk("R10 out enabled", int'(irq_o), 1);
    en_out_i = 0;
  endtask

  task automatic t_iso_in;
    do_reset(2'b01, 1'b1, 2'd3);
    tick;
    chk_all("R6 bank0 free", st(0,0,1,1,0,0));
    clr_fifo_i = 1; tick;
    chk_all("R8 in ack pending", st(0,0,1,1,0,0));
    clr_in_i = 1; tick;
    chk_all("R6 ack keeps bank", st(0,0,0,1,0,0));
    clr_fifo_i = 1; tick;
    chk_all("R7 queue bank0", st(0,0,1,1,1,1));
    clr_in_i = 1; tick;
    clr_fifo_i = 1; tick;
    chk_all("R7 queue bank1", st(0,0,1,1,3,2));
    clr_in_i = 1; tick;
    clr_fifo_i = 1; tick;
    chk_all("R7 wrap all busy", st(0,0,0,0,7,0));
    in_sent_i = 1; tick;
    chk_all("R12 drain bank0", st(0,0,1,1,6,0));
    in_sent_i = 1; tick;
    in_sent_i = 1; tick;
    chk_all("R12 drain rest", st(0,0,1,1,0,0));
    in_sent_i = 1; tick;
    chk_all("R12 sent on free dropped", st(0,0,1,1,0,0));
    out_evt_i = 1; setup_evt_i = 1; tick;
    chk_all("R9 in ep ignores out/setup", st(0,0,1,1,0,0));
  endtask

  task automatic t_intr_single;
    do_reset(2'b11, 1'b0, 2'd0);
    out_evt_i = 1; tick;
    chk_all("R5 single bank full", st(0,1,0,1,1,0));
    clr_out_i = 1; tick;
    clr_fifo_i = 1; tick;
    chk_all("R7 count 0 as one bank", st(0,0,0,0,0,0));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_control;
    t_bulk_out;
    t_iso_in;
    t_intr_single;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule